// File: doc/BRIEF.md
# Single-Channel Word DMA Engine

This block is one DMA channel. It copies 32-bit words between a peripheral-side address and a memory-side address. Software sets the channel up through six word-wide registers: a control word, a live status word, one pointer for each side and two sequence words. Word moves run through two simple valid/ready ports. One port issues reads and takes back the data. The other port issues writes. A flag on each port tells which side the access targets.

A channel works in one of two modes. In single-shot mode it moves one block and then turns itself off. In continuous mode it treats a buffer as two halves and never stops on its own. At the end of each half it flags end of count and flips a phase bit. At the end of each whole buffer it reloads both pointers from their registers. Software can therefore retarget the next buffer while the current one is still running. Transfers can be paced by one of several peripheral request lines. Parking the selector on the reserved value 31, or setting the hold bit, freezes the channel while it stays enabled, so software can read the live remaining count.

Top module: `dmac_channel`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and neither port asserts valid.
- R2: Register index 0 is the control word. Its fields are enable bit 31, interrupt enable bit 30, hold bit 29, direction bit 28, single-shot bit 27, paced bit 21, request select bits 20:16 and count bits 15:2, and all other bits read zero. Index 2 is the peripheral pointer and index 3 the memory pointer, and bits 1:0 of both read zero. Indices 4 and 5 are sequence words that read back all 32 bits as written.
- R3: Index 1 is the status word: busy bit 31, pending bit 30, halted bit 29, phase bit 28, and bits 15:2 holding the words still to move in the current block or half minus one. This count is updated after every word.
- R4: With direction 0 the channel reads at the peripheral pointer (`rd_mem_o`=0) and writes at the memory pointer (`wr_mem_o`=1). Direction 1 swaps the two sides. Data passes through unchanged, and both pointers advance by 4 after each word.
- R5: In single-shot mode a block moves count+1 words. After the last word, busy falls, the enable bit clears and pending sets.
- R6: In continuous mode every count+1 words sets pending and toggles phase. Pointers keep advancing across a half boundary. After two halves they reload from the pointer registers, including values written while the channel runs.
- R7: With the paced bit set, one word starts for each cycle the selected request line is high while the channel waits, and other lines have no effect. With the paced bit clear, words start back to back.
- R8: With select 31 or hold set, no new word starts. Busy and halted read 1 and the count stays frozen. Clearing the condition resumes the block where it stopped.
- R9: Writing the status word with bit 30 set clears pending. Writing it with bit 30 clear leaves pending unchanged.
- R10: `irq_o` is high exactly when pending and the interrupt enable bit are both set.
- R11: Clearing enable makes busy read 0 one cycle after the write takes effect, and no valid is raised afterwards.
- R12: A raised valid stays high, with a stable address and write data, until ready is seen, unless enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_idx_i` (combinational) |
| req_i | input | N_REQ | Peripheral request lines |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read accepted, `rd_data_i` valid |
| rd_mem_o | output | 1 | Read targets the memory side |
| rd_addr_o | output | 32 | Read byte address |
| rd_data_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted |
| wr_mem_o | output | 1 | Write targets the memory side |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Write data |
| irq_o | output | 1 | End-of-count interrupt |

## Verification
Single-shot blocks in both directions are run with directed and random counts and aligned pointers. Counts include the one-word block, and read data depends on the address and side, which exposes swapped pointers, off-by-one block lengths and wrong side flags. Paced runs pulse the selected line and also lines that were not selected, which separates correct line decoding from free running. A paused run checks the frozen live count under both the parked selector and the hold bit, and then checks that the block resumes. A continuous run steps word by word across two half boundaries while a pointer is rewritten mid-buffer, which separates reloading at the half boundary from reloading at the full-buffer boundary. Random ready stalls on both ports test that requests stay stable.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int WORD_W    = 32;
    localparam int PTR_W     = WORD_W - 2;
    localparam int CNT_W     = 14;
    localparam int SEL_W     = 5;
    localparam int REG_IDX_W = 3;

    localparam logic [SEL_W-1:0] SEL_PARKED = '1;

    // control word bit positions
    localparam int CB_EN    = 31;
    localparam int CB_IE    = 30;
    localparam int CB_HOLD  = 29;
    localparam int CB_DIR   = 28;
    localparam int CB_ONCE  = 27;
    localparam int CB_PACED = 21;
    localparam int CB_SEL   = 16;
    localparam int CB_CNT   = 2;

    // status word bit positions
    localparam int SB_BUSY  = 31;
    localparam int SB_PEND  = 30;
    localparam int SB_HALT  = 29;
    localparam int SB_PHASE = 28;

    typedef enum logic [REG_IDX_W-1:0] {
        RI_CTRL = 3'd0,
        RI_STAT = 3'd1,
        RI_PPTR = 3'd2,
        RI_MPTR = 3'd3,
        RI_PSEQ = 3'd4,
        RI_MSEQ = 3'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        ES_OFF,
        ES_WAIT,
        ES_READ,
        ES_WRITE
    } eng_state_e;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             hold;
        logic             dir;
        logic             once;
        logic             paced;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] wcount;
    } ctrl_t;

    typedef struct packed {
        logic             busy;
        logic             pending;
        logic             halted;
        logic             phase;
        logic [CNT_W-1:0] remain;
    } stat_t;

    function automatic logic [WORD_W-1:0] ctrl_pack(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CB_EN]    = c.en;
        w[CB_IE]    = c.ie;
        w[CB_HOLD]  = c.hold;
        w[CB_DIR]   = c.dir;
        w[CB_ONCE]  = c.once;
        w[CB_PACED] = c.paced;
        w[CB_SEL +: SEL_W] = c.sel;
        w[CB_CNT +: CNT_W] = c.wcount;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] stat_pack(input stat_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SB_BUSY]  = s.busy;
        w[SB_PEND]  = s.pending;
        w[SB_HALT]  = s.halted;
        w[SB_PHASE] = s.phase;
        w[CB_CNT +: CNT_W] = s.remain;
        return w;
    endfunction
endpackage

// File: rtl/dmac_reqsel.sv
module dmac_reqsel
    import dmac_pkg::*;
#(
    parameter int N_REQ = 31
) (
    input  logic [N_REQ-1:0] req,
    input  logic [SEL_W-1:0] sel,
    input  logic             paced,
    output logic             go,
    output logic             parked
);
    logic [N_REQ-1:0] hit;

    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_line
            assign hit[i] = req[i] && (sel == SEL_W'(i));
        end
    endgenerate

    assign parked = (sel == SEL_PARKED);
    assign go     = !parked && (!paced || (|hit));
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic                 pend_set,
    input  logic                 once_done,
    input  logic                 busy,
    input  logic                 halted,
    input  logic                 phase,
    input  logic [CNT_W-1:0]     remain,
    output ctrl_t                ctrl,
    output logic [PTR_W-1:0]     pptr,
    output logic [PTR_W-1:0]     mptr,
    output logic                 pending
);
    ctrl_t             ctrl_q;
    logic [PTR_W-1:0]  pptr_q, mptr_q;
    logic [WORD_W-1:0] pseq_q, mseq_q;
    logic              pend_q;
    reg_idx_e          sel_idx;
    stat_t             stat;

    assign sel_idx = reg_idx_e'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pptr_q <= '0;
            mptr_q <= '0;
            pseq_q <= '0;
            mseq_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (once_done) begin
                ctrl_q.en <= 1'b0;
            end
            if (pend_set) begin
                pend_q <= 1'b1;
            end else if (wr && sel_idx == RI_STAT && wdata[SB_PEND]) begin
                pend_q <= 1'b0;
            end
            if (wr) begin
                case (sel_idx)
                    RI_CTRL: begin
                        ctrl_q.en     <= wdata[CB_EN];
                        ctrl_q.ie     <= wdata[CB_IE];
                        ctrl_q.hold   <= wdata[CB_HOLD];
                        ctrl_q.dir    <= wdata[CB_DIR];
                        ctrl_q.once   <= wdata[CB_ONCE];
                        ctrl_q.paced  <= wdata[CB_PACED];
                        ctrl_q.sel    <= wdata[CB_SEL +: SEL_W];
                        ctrl_q.wcount <= wdata[CB_CNT +: CNT_W];
                    end
                    RI_PPTR: pptr_q <= wdata[WORD_W-1:2];
                    RI_MPTR: mptr_q <= wdata[WORD_W-1:2];
                    RI_PSEQ: pseq_q <= wdata;
                    RI_MSEQ: mseq_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        stat.busy    = busy;
        stat.pending = pend_q;
        stat.halted  = halted;
        stat.phase   = phase;
        stat.remain  = remain;
    end

    always_comb begin
        case (sel_idx)
            RI_CTRL: rdata = ctrl_pack(ctrl_q);
            RI_STAT: rdata = stat_pack(stat);
            RI_PPTR: rdata = {pptr_q, 2'b00};
            RI_MPTR: rdata = {mptr_q, 2'b00};
            RI_PSEQ: rdata = pseq_q;
            RI_MSEQ: rdata = mseq_q;
            default: rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign pptr    = pptr_q;
    assign mptr    = mptr_q;
    assign pending = pend_q;
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              hold,
    input  logic              dir,
    input  logic              once,
    input  logic [CNT_W-1:0]  wcount,
    input  logic              go,
    input  logic              parked,
    input  logic [PTR_W-1:0]  pptr_sh,
    input  logic [PTR_W-1:0]  mptr_sh,
    output logic              rd_valid,
    output logic              rd_mem,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_valid,
    output logic              wr_mem,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              halted,
    output logic              phase,
    output logic [CNT_W-1:0]  remain,
    output logic              eoc,
    output logic              once_done
);
    eng_state_e        st_q;
    logic [PTR_W-1:0]  pp_q, mp_q;
    logic [CNT_W-1:0]  rem_q;
    logic              ph_q;
    logic [WORD_W-1:0] buf_q;
    logic              word_done;
    logic              last_word;
    logic              frozen;

    assign frozen    = parked || hold;
    assign last_word = (rem_q == '0);
    assign word_done = en && (st_q == ES_WRITE) && wr_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ES_OFF;
            pp_q  <= '0;
            mp_q  <= '0;
            rem_q <= '0;
            ph_q  <= 1'b0;
            buf_q <= '0;
        end else if (!en) begin
            st_q <= ES_OFF;
        end else begin
            case (st_q)
                ES_OFF: begin
                    pp_q  <= pptr_sh;
                    mp_q  <= mptr_sh;
                    rem_q <= wcount;
                    ph_q  <= 1'b0;
                    st_q  <= ES_WAIT;
                end
                ES_WAIT: begin
                    if (go && !frozen) begin
                        st_q <= ES_READ;
                    end
                end
                ES_READ: begin
                    if (rd_ready) begin
                        buf_q <= rd_data;
                        st_q  <= ES_WRITE;
                    end
                end
                ES_WRITE: begin
                    if (wr_ready) begin
                        pp_q <= pp_q + 1'b1;
                        mp_q <= mp_q + 1'b1;
                        if (!last_word) begin
                            rem_q <= rem_q - 1'b1;
                            st_q  <= ES_WAIT;
                        end else if (once) begin
                            st_q <= ES_OFF;
                        end else begin
                            rem_q <= wcount;
                            ph_q  <= ~ph_q;
                            st_q  <= ES_WAIT;
                            if (ph_q) begin
                                pp_q <= pptr_sh;
                                mp_q <= mptr_sh;
                            end
                        end
                    end
                end
                default: st_q <= ES_OFF;
            endcase
        end
    end

    assign rd_valid  = en && (st_q == ES_READ);
    assign wr_valid  = en && (st_q == ES_WRITE);
    assign rd_mem    = dir;
    assign wr_mem    = !dir;
    assign rd_addr   = {(dir ? mp_q : pp_q), 2'b00};
    assign wr_addr   = {(dir ? pp_q : mp_q), 2'b00};
    assign wr_data   = buf_q;
    assign busy      = (st_q != ES_OFF);
    assign halted    = (st_q == ES_WAIT) && frozen;
    assign phase     = ph_q;
    assign remain    = rem_q;
    assign eoc       = word_done && last_word;
    assign once_done = eoc && once;
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int N_REQ = 31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_i,
    input  logic [REG_IDX_W-1:0] reg_idx_i,
    input  logic [WORD_W-1:0]    reg_wdata_i,
    output logic [WORD_W-1:0]    reg_rdata_o,
    input  logic [N_REQ-1:0]     req_i,
    output logic                 rd_valid_o,
    input  logic                 rd_ready_i,
    output logic                 rd_mem_o,
    output logic [WORD_W-1:0]    rd_addr_o,
    input  logic [WORD_W-1:0]    rd_data_i,
    output logic                 wr_valid_o,
    input  logic                 wr_ready_i,
    output logic                 wr_mem_o,
    output logic [WORD_W-1:0]    wr_addr_o,
    output logic [WORD_W-1:0]    wr_data_o,
    output logic                 irq_o
);
    ctrl_t            ctrl;
    logic [PTR_W-1:0] pptr_sh, mptr_sh;
    logic             en_w, busy_w, halted_w, eoc_w, pend_w, once_done_w;
    logic             phase_w, go_w, parked_w;
    logic [CNT_W-1:0] remain_w;

    dmac_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr_i),
        .idx       (reg_idx_i),
        .wdata     (reg_wdata_i),
        .rdata     (reg_rdata_o),
        .pend_set  (eoc_w),
        .once_done (once_done_w),
        .busy      (busy_w),
        .halted    (halted_w),
        .phase     (phase_w),
        .remain    (remain_w),
        .ctrl      (ctrl),
        .pptr      (pptr_sh),
        .mptr      (mptr_sh),
        .pending   (pend_w)
    );

    dmac_reqsel #(.N_REQ(N_REQ)) u_reqsel (
        .req    (req_i),
        .sel    (ctrl.sel),
        .paced  (ctrl.paced),
        .go     (go_w),
        .parked (parked_w)
    );

    assign en_w = ctrl.en;

    dmac_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .en        (en_w),
        .hold      (ctrl.hold),
        .dir       (ctrl.dir),
        .once      (ctrl.once),
        .wcount    (ctrl.wcount),
        .go        (go_w),
        .parked    (parked_w),
        .pptr_sh   (pptr_sh),
        .mptr_sh   (mptr_sh),
        .rd_valid  (rd_valid_o),
        .rd_mem    (rd_mem_o),
        .rd_addr   (rd_addr_o),
        .rd_ready  (rd_ready_i),
        .rd_data   (rd_data_i),
        .wr_valid  (wr_valid_o),
        .wr_mem    (wr_mem_o),
        .wr_addr   (wr_addr_o),
        .wr_data   (wr_data_o),
        .wr_ready  (wr_ready_i),
        .busy      (busy_w),
        .halted    (halted_w),
        .phase     (phase_w),
        .remain    (remain_w),
        .eoc       (eoc_w),
        .once_done (once_done_w)
    );

    assign irq_o = pend_w && ctrl.ie;
endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [31:0] rd_addr,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        en,
    input logic        busy,
    input logic        halted,
    input logic        eoc,
    input logic        pend
);
    AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> (rd_valid && $stable(rd_addr)) || !en); // R12
    AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)) || !en); // R12
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_valid)); // R4
    AST_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy); // R11
    AST_NO_READ_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted |=> !rd_valid); // R8
    AST_EOC_PENDS: assert property (@(posedge clk) disable iff (rst)
        eoc |=> pend); // R5
endmodule

bind dmac_channel dmac_channel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid_o),
    .rd_ready (rd_ready_i),
    .rd_addr  (rd_addr_o),
    .wr_valid (wr_valid_o),
    .wr_ready (wr_ready_i),
    .wr_addr  (wr_addr_o),
    .wr_data  (wr_data_o),
    .en       (en_w),
    .busy     (busy_w),
    .halted   (halted_w),
    .eoc      (eoc_w),
    .pend     (pend_w)
);

// File: tb/dmac_channel_tb.sv
module dmac_channel_tb_top;
    localparam int N_REQ = 31;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_idx_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [N_REQ-1:0] req_i = '0;
    logic        rd_valid_o, rd_mem_o, wr_valid_o, wr_mem_o, irq_o;
    logic        rd_ready_i = 1'b0, wr_ready_i = 1'b0;
    logic [31:0] rd_addr_o, wr_addr_o, wr_data_o;
    logic [31:0] rd_data_i = '0;

    always #4 clk = ~clk;

    dmac_channel #(.N_REQ(N_REQ)) dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_i(reg_wr_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .req_i(req_i),
        .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_mem_o(rd_mem_o),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_mem_o(wr_mem_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .irq_o(irq_o)
    );

    int vectors = 0, miscompares = 0;
    int hs_vectors = 0, hs_fails = 0;
    int cyc = 0;

    function automatic logic [31:0] src_word(input logic [31:0] a, input logic mem);
        return a ^ (mem ? 32'h5A5A_0000 : 32'hC3C3_0000);
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic en, ie, hold, dir, once, paced,
                                            input logic [4:0] sel, input logic [13:0] wc);
        return {en, ie, hold, dir, once, 5'b0, paced, sel, wc, 2'b00};
    endfunction

    // ---------------- responder / write log ----------------
    logic [31:0] log_addr [0:511];
    logic [31:0] log_data [0:511];
    logic        log_mem  [0:511];
    int          n_wr = 0;
    bit          hs_chk = 1'b1;
    logic        rd_wait = 1'b0, wr_wait = 1'b0;
    logic [31:0] rd_hold_a = '0, wr_hold_a = '0, wr_hold_d = '0;

    always @(negedge clk) begin
        if (rst) begin
            rd_ready_i = 1'b0;
            wr_ready_i = 1'b0;
        end else begin
            if (hs_chk && rd_wait) begin
                hs_vectors++;
                if (!(rd_valid_o && rd_addr_o == rd_hold_a)) begin
                    hs_fails++;
                    $display("FAIL R12 read held: actual v=%0d 0x%08h expected v=1 0x%08h",
                             rd_valid_o, rd_addr_o, rd_hold_a);
                end
            end
            if (hs_chk && wr_wait) begin
                hs_vectors++;
                if (!(wr_valid_o && wr_addr_o == wr_hold_a && wr_data_o == wr_hold_d)) begin
                    hs_fails++;
                    $display("FAIL R12 write held: actual 0x%08h/0x%08h expected 0x%08h/0x%08h",
                             wr_addr_o, wr_data_o, wr_hold_a, wr_hold_d);
                end
            end
            rd_ready_i = ($urandom_range(3) != 0);
            wr_ready_i = ($urandom_range(3) != 0);
            rd_data_i  = src_word(rd_addr_o, rd_mem_o);
            if (wr_valid_o && wr_ready_i && n_wr < 512) begin
                log_addr[n_wr] = wr_addr_o;
                log_data[n_wr] = wr_data_o;
                log_mem[n_wr]  = wr_mem_o;
                n_wr++;
            end
            rd_wait   = rd_valid_o && !rd_ready_i;
            wr_wait   = wr_valid_o && !wr_ready_i;
            rd_hold_a = rd_addr_o;
            wr_hold_a = wr_addr_o;
            wr_hold_d = wr_data_o;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==",
                     vectors + hs_vectors + 1, miscompares + hs_fails + 1);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx_i = idx;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        req_i[line] = 1'b1;
        @(negedge clk);
        req_i = '0;
        repeat (30) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            reg_read(3'd1, s);
            if (!s[31]) break;
        end
    endtask

    task automatic check_words(input int base, input int first, input int cnt, input logic dir,
                               input logic [31:0] p0, input logic [31:0] m0, input string tag);
        for (int i = 0; i < cnt; i++) begin
            logic [31:0] pa, ma;
            pa = p0 + 32'(4 * (first + i));
            ma = m0 + 32'(4 * (first + i));
            chk({tag, " addr"}, log_addr[base+i], dir ? pa : ma);
            chk({tag, " data"}, log_data[base+i], dir ? src_word(ma, 1'b1) : src_word(pa, 1'b0));
            chk({tag, " side"}, {31'b0, log_mem[base+i]}, {31'b0, !dir});
        end
    endtask

    task automatic run_oneshot(input logic dir, input logic [13:0] wc, input logic [31:0] p0,
                               input logic [31:0] m0, input logic ie);
        int base;
        logic [31:0] s;
        reg_write(3'd2, p0);
        reg_write(3'd3, m0);
        base = n_wr;
        reg_write(3'd0, mk_ctrl(1, ie, 0, dir, 1, 0, 5'd0, wc));
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R5 word total", 32'(n_wr - base), 32'(wc) + 1);
        check_words(base, 0, int'(wc) + 1, dir, p0, m0, "R4");
        reg_read(3'd0, s);
        chk("R5 enable cleared", {31'b0, s[31]}, 32'd0);
        reg_read(3'd1, s);
        chk("R5 pending set", {31'b0, s[30]}, 32'd1);
        chk("R10 irq", {31'b0, irq_o}, {31'b0, ie});
        reg_write(3'd1, 32'h0000_0000);
        reg_read(3'd1, s);
        chk("R9 zero write keeps pending", {31'b0, s[30]}, 32'd1);
        reg_write(3'd1, 32'h4000_0000);
        reg_read(3'd1, s);
        chk("R9 clear pending", {31'b0, s[30]}, 32'd0);
        chk("R10 irq low", {31'b0, irq_o}, 32'd0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] s;
        int base, snap;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            reg_read(3'(i), s);
            chk("R1 register reset", s, 32'd0);
        end
        chk("R1 irq", {31'b0, irq_o}, 32'd0);
        chk("R1 valids", {30'b0, rd_valid_o, wr_valid_o}, 32'd0);

        // R2 register map
        reg_write(3'd2, 32'h0000_1237);
        reg_read(3'd2, s);  chk("R2 pptr align", s, 32'h0000_1234);
        reg_write(3'd3, 32'hFFFF_FFFF);
        reg_read(3'd3, s);  chk("R2 mptr align", s, 32'hFFFF_FFFC);
        reg_write(3'd4, 32'hDEAD_BEEF);
        reg_read(3'd4, s);  chk("R2 pseq", s, 32'hDEAD_BEEF);
        reg_write(3'd5, 32'h1234_5678);
        reg_read(3'd5, s);  chk("R2 mseq", s, 32'h1234_5678);
        reg_write(3'd0, 32'h07C0_0003);
        reg_read(3'd0, s);  chk("R2 undefined ctrl bits", s, 32'd0);
        reg_write(3'd0, mk_ctrl(0, 1, 0, 1, 1, 1, 5'd9, 14'd100));
        reg_read(3'd0, s);  chk("R2 ctrl readback", s, mk_ctrl(0, 1, 0, 1, 1, 1, 5'd9, 14'd100));
        reg_write(3'd0, 32'd0);

        // R4/R5 directed single-shot blocks
        run_oneshot(1'b0, 14'd3, 32'h0000_1000, 32'h0000_4000, 1'b1);
        run_oneshot(1'b1, 14'd0, 32'h0000_2200, 32'h0001_0000, 1'b0);
        // random single-shot blocks
        for (int k = 0; k < 5; k++) begin
            run_oneshot(1'($urandom_range(1)), 14'($urandom_range(20)),
                        $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
                        1'($urandom_range(1)));
        end

        // R7 paced transfers, R8 pause, R3 live count
        reg_write(3'd2, 32'h0000_3000);
        reg_write(3'd3, 32'h0000_6000);
        base = n_wr;
        reg_write(3'd0, mk_ctrl(1, 0, 0, 0, 1, 1, 5'd7, 14'd15));
        pulse(6); pulse(8); pulse(6); pulse(8);
        chk("R7 other lines ignored", 32'(n_wr - base), 32'd0);
        pulse(7); pulse(7); pulse(7);
        chk("R7 one word per request", 32'(n_wr - base), 32'd3);
        reg_read(3'd1, s);
        chk("R3 live count", 32'(s[15:2]), 32'd12);
        reg_write(3'd0, mk_ctrl(1, 0, 0, 0, 1, 0, 5'd31, 14'd15));
        repeat (40) @(negedge clk);
        reg_read(3'd1, s);
        chk("R8 parked busy/halted", {30'b0, s[31], s[29]}, 32'd3);
        chk("R8 parked count frozen", 32'(s[15:2]), 32'd12);
        chk("R8 parked no words", 32'(n_wr - base), 32'd3);
        reg_write(3'd0, mk_ctrl(1, 0, 1, 0, 1, 0, 5'd7, 14'd15));
        repeat (40) @(negedge clk);
        reg_read(3'd1, s);
        chk("R8 hold halted", {31'b0, s[29]}, 32'd1);
        chk("R8 hold no words", 32'(n_wr - base), 32'd3);
        reg_write(3'd0, mk_ctrl(1, 0, 0, 0, 1, 0, 5'd7, 14'd15));
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R8 resumed total", 32'(n_wr - base), 32'd16);
        check_words(base, 0, 16, 1'b0, 32'h0000_3000, 32'h0000_6000, "R8 resumed");
        reg_write(3'd1, 32'h4000_0000);

        // R6 continuous double-buffered
        reg_write(3'd2, 32'h0000_2000);
        reg_write(3'd3, 32'h0000_8000);
        base = n_wr;
        reg_write(3'd0, mk_ctrl(1, 1, 0, 0, 0, 1, 5'd2, 14'd1));
        pulse(2); pulse(2);
        chk("R6 first half words", 32'(n_wr - base), 32'd2);
        reg_read(3'd1, s);
        chk("R6 half end busy/pend/phase", {28'b0, s[31:28]}, 32'hD);
        chk("R3 count reloaded", 32'(s[15:2]), 32'd1);
        chk("R10 irq continuous", {31'b0, irq_o}, 32'd1);
        reg_write(3'd1, 32'h4000_0000);
        reg_write(3'd3, 32'h0000_A000);
        pulse(2); pulse(2);
        chk("R6 second half words", 32'(n_wr - base), 32'd4);
        reg_read(3'd1, s);
        chk("R6 buffer end busy/pend/phase", {28'b0, s[31:28]}, 32'hC);
        reg_write(3'd1, 32'h4000_0000);
        pulse(2);
        chk("R6 next buffer word", 32'(n_wr - base), 32'd5);
        check_words(base, 0, 4, 1'b0, 32'h0000_2000, 32'h0000_8000, "R6 continues");
        check_words(base + 4, 0, 1, 1'b0, 32'h0000_2000, 32'h0000_A000, "R6 reload");

        // R11 disable while running back to back
        reg_write(3'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 5'd2, 14'd3));
        repeat (20) @(negedge clk);
        hs_chk = 1'b0;
        reg_write(3'd0, 32'd0);
        reg_read(3'd1, s);
        chk("R11 busy dropped", {31'b0, s[31]}, 32'd0);
        snap = n_wr;
        repeat (30) @(negedge clk);
        chk("R11 no words after disable", 32'(n_wr - snap), 32'd0);
        chk("R11 no valid", {30'b0, rd_valid_o, wr_valid_o}, 32'd0);
        hs_chk = 1'b1;

        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==",
                 vectors + hs_vectors, miscompares + hs_fails);
        $finish;
    end
endmodule